// File: doc/BRIEF.md
# Discharge lamp start controller

This block sequences the start of a high-pressure discharge lamp. When the host raises the lamp request, the controller turns on the igniter enable. The igniter then produces high-voltage start pulses, and the controller watches the lit signal that comes back from an optical detector. If the lamp is seen lit, the controller stops the igniter and holds a run indication while the lamp burns on its steady supply. If the lamp has not lit when a fixed start window of 1.5 s runs out, the controller abandons the attempt and raises a fault output.

The lit input is asynchronous. It passes through a two-stage synchroniser and then a qualifier that requires it to stay high for a set number of consecutive cycles before it counts as lit. Any low sample clears it at once. If the lamp goes dark while running, the controller moves to the fault state. The fault state is held until the host withdraws the request. Dropping the request in any state returns the block to idle.

Top module: `lamp_start_ctrl`

## Requirements
- R1: While reset is asserted and after it is released, with no request, `ign_en`, `run_on` and `fault_off` are all low.
- R2: In idle, `lit_in` alone has no effect and all outputs stay low. A high `lamp_req` seen at a clock edge makes `ign_en` high from that edge on, even if the lamp is already lit.
- R3: The start window lasts TIMEOUT = CLK_HZ + CLK_HZ/2 cycles. If the lamp is not qualified as lit, `ign_en` stays high for exactly TIMEOUT cycles, and at the next edge `ign_en` falls and `fault_off` rises.
- R4: `lit_in` counts as lit only after it has been high for DEB_CYC consecutive synchronised cycles. `run_on` rises DEB_CYC+3 edges after `lit_in` rises during ignition. A high pulse shorter than DEB_CYC cycles is ignored and ignition continues.
- R5: If the lit qualification first holds in the last cycle of the start window, the block enters run and not fault.
- R6: In run, `ign_en` is low and `run_on` is high. A fall of `lit_in` moves the block to fault: `run_on` is still high 3 edges after the fall, and `fault_off` is high from the 4th edge.
- R7: `fault_off` stays high while `lamp_req` stays high, even if `lit_in` returns. The edge that first sees `lamp_req` low clears it.
- R8: A low `lamp_req` during ignition or run returns the block to idle at the next edge. A later request starts a fresh, full-length start window.
- R9: At most one of `ign_en`, `run_on`, `fault_off` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| lamp_req | input | 1 | Host request to light the lamp (level) |
| lit_in | input | 1 | Asynchronous lamp-lit signal from the optical detector |
| ign_en | output | 1 | Igniter enable, high during the start window |
| run_on | output | 1 | Lamp lit and running |
| fault_off | output | 1 | Start failed or lamp lost, held until the request is released |

## Verification
The bench builds the block with CLK_HZ = 40, which gives a 60-cycle start window, and DEB_CYC = 4. At these values the exact window end, the case where the lit qualification lands in the last window cycle or one cycle too late, and pulses one cycle shorter than the qualifier length can all be reached in a few hundred cycles. Each latency is checked on both sides of the edge where the output should change: one edge before and the edge itself.

// File: rtl/lamp_start_pkg.sv
package lamp_start_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_IGNITE = 2'd1,
    ST_RUN    = 2'd2,
    ST_FAIL   = 2'd3
  } lamp_state_e;
endpackage

// File: rtl/lamp_start_sync.sv
module lamp_start_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[0] <= 1'b0;
          else        chain_q[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[i] <= 1'b0;
          else        chain_q[i] <= chain_q[i-1];
        end
      end
    end
  endgenerate

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/lamp_start_filter.sv
// Qualifies the synchronised lit level: rises only after DEB_CYC high
// samples in a row, falls on the first low sample.
module lamp_start_filter #(
  parameter int DEB_CYC = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic lit_s,
  output logic lit_ok
);
  localparam int CW = $clog2(DEB_CYC + 1);
  localparam logic [CW-1:0] CMAX = CW'(DEB_CYC);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = !lit_s || (cnt_q != CMAX);
    if (!lit_s) cnt_d = '0;
    else        cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign lit_ok = (cnt_q == CMAX);

  // R6: a low sample removes the qualification at the next edge
  p_fall_fast_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !lit_s |=> !lit_ok);

  // R4: qualification only ever follows a high sample
  p_rise_needs_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lit_ok) |-> $past(lit_s));
endmodule

// File: rtl/lamp_start_timer.sv
module lamp_start_timer #(
  parameter int unsigned LIMIT = 150_000_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  output logic expire
);
  localparam int TW = $clog2(LIMIT + 1);
  localparam logic [TW-1:0] LAST = TW'(LIMIT - 1);

  logic [TW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = active || (cnt_q != '0);
    cnt_d  = active ? cnt_q + 1'b1 : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign expire = active && (cnt_q == LAST);

  // R3: the count never runs past the window while ignition is active
  p_window_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> (cnt_q <= LAST));

  // R8: a window always starts from zero
  p_fresh_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !$past(active)) |-> (cnt_q == '0));
endmodule

// File: rtl/lamp_start_fsm.sv
module lamp_start_fsm
  import lamp_start_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req,
  input  logic        lit_ok,
  input  logic        expire,
  output lamp_state_e state
);
  lamp_state_e state_d;

  always_comb begin
    state_d = state;
    unique case (state)
      ST_IDLE:   if (req) state_d = ST_IGNITE;
      ST_IGNITE: begin
        if (!req)        state_d = ST_IDLE;
        else if (lit_ok) state_d = ST_RUN;
        else if (expire) state_d = ST_FAIL;
      end
      ST_RUN: begin
        if (!req)         state_d = ST_IDLE;
        else if (!lit_ok) state_d = ST_FAIL;
      end
      ST_FAIL:   if (!req) state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= state_d;
  end

  // R8: a released request always lands in idle
  p_release_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !req |=> (state == ST_IDLE));

  // R7: fault persists while the request stays high
  p_fault_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_FAIL && req) |=> (state == ST_FAIL));

  // R4: run is entered only with a qualified lit signal
  p_run_entry_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RUN && $past(state) != ST_RUN) |-> $past(lit_ok));
endmodule

// File: rtl/lamp_start_ctrl.sv
module lamp_start_ctrl
  import lamp_start_pkg::*;
#(
  parameter int unsigned CLK_HZ      = 100_000_000,
  parameter int          DEB_CYC     = 1000,
  parameter int          SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic lamp_req,
  input  logic lit_in,
  output logic ign_en,
  output logic run_on,
  output logic fault_off
);
  localparam int unsigned TIMEOUT_CYC = CLK_HZ + CLK_HZ / 2;

  logic        lit_s;
  logic        lit_ok;
  logic        expire;
  lamp_state_e state;

  lamp_start_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(lit_in), .q(lit_s)
  );

  lamp_start_filter #(.DEB_CYC(DEB_CYC)) u_filter (
    .clk(clk), .rst_n(rst_n), .lit_s(lit_s), .lit_ok(lit_ok)
  );

  lamp_start_timer #(.LIMIT(TIMEOUT_CYC)) u_timer (
    .clk(clk), .rst_n(rst_n), .active(state == ST_IGNITE), .expire(expire)
  );

  lamp_start_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .req(lamp_req), .lit_ok(lit_ok),
    .expire(expire), .state(state)
  );

  assign ign_en    = (state == ST_IGNITE);
  assign run_on    = (state == ST_RUN);
  assign fault_off = (state == ST_FAIL);

  // R9: outputs are mutually exclusive
  p_one_output_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ign_en, run_on, fault_off}));

  // R3: an unlit window end raises the fault
  p_timeout_fault_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && !lit_ok && lamp_req) |=> fault_off);

  // R6: the igniter is never on while running
  p_run_no_ign_r6: assert property (@(posedge clk) disable iff (!rst_n)
    run_on |-> !ign_en);
endmodule

// File: tb/lamp_start_ctrl_bench.sv
module lamp_start_ctrl_bench;
  localparam int unsigned CLK_HZ = 40;
  localparam int          DEB    = 4;
  localparam int          TWIN   = CLK_HZ + CLK_HZ / 2;  // 60 cycles
  localparam int          WD_CYC = 20000;

  logic clk, rst_n, lamp_req, lit_in;
  logic ign_en, run_on, fault_off;
  int   checks, failures, cyc;
  bit   done;

  lamp_start_ctrl #(.CLK_HZ(CLK_HZ), .DEB_CYC(DEB), .SYNC_STAGES(2)) u_lamp_start_ctrl (
    .clk(clk), .rst_n(rst_n), .lamp_req(lamp_req), .lit_in(lit_in),
    .ign_en(ign_en), .run_on(run_on), .fault_off(fault_off)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic report();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == WD_CYC && !done) begin
      failures = failures + 1;
      $display("FAIL watchdog: run incomplete, cycles=%0d expected < %0d", cyc, WD_CYC);
      report();
      $finish;
    end
  end

  // expected pattern is {ign_en, run_on, fault_off}
  task automatic chk(string req, string what, logic [2:0] exp);
    logic [2:0] act;
    act = {ign_en, run_on, fault_off};
    checks = checks + 1;
    if (act !== exp) begin
      failures = failures + 1;
      $display("FAIL %s %s: actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  task automatic edges(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic settle();
    lamp_req = 1'b0;
    lit_in   = 1'b0;
    edges(8);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; lamp_req = 1'b0; lit_in = 1'b0;
    edges(3);
    chk("R1", "during reset", 3'b000);
    rst_n = 1'b1;
    edges(3);
    chk("R1", "after reset", 3'b000);
  endtask

  task automatic t_idle_lit();
    lit_in = 1'b1;
    edges(10);
    chk("R2", "lit without request", 3'b000);
    lamp_req = 1'b1;
    edges(1);
    chk("R2", "request starts ignition with lamp lit", 3'b100);
    edges(1);
    chk("R4", "already-qualified lit enters run", 3'b010);
    settle();
  endtask

  task automatic t_timeout();
    lamp_req = 1'b1;
    edges(1);
    chk("R2", "ignition on first edge", 3'b100);
    edges(TWIN - 1);
    chk("R3", "igniter still on in last window cycle", 3'b100);
    edges(1);
    chk("R3", "fault after window", 3'b001);
    settle();
  endtask

  task automatic t_glitch_then_lit();
    lamp_req = 1'b1;
    edges(1);
    lit_in = 1'b1;
    edges(DEB - 1);
    lit_in = 1'b0;
    edges(6);
    chk("R4", "short pulse ignored", 3'b100);
    lit_in = 1'b1;
    edges(DEB + 2);
    chk("R4", "one edge before run", 3'b100);
    edges(1);
    chk("R4", "run after qualification", 3'b010);
    chk("R6", "igniter off in run", 3'b010);
  endtask

  task automatic t_loss_in_run();
    lit_in = 1'b0;
    edges(3);
    chk("R6", "run held 3 edges after loss", 3'b010);
    edges(1);
    chk("R6", "fault on 4th edge after loss", 3'b001);
    lit_in = 1'b1;
    edges(10);
    chk("R7", "fault held though lit returns", 3'b001);
    lamp_req = 1'b0;
    edges(1);
    chk("R7", "release clears fault", 3'b000);
    settle();
  endtask

  task automatic t_lit_at_window_end(int wait_n, logic [2:0] exp, string what);
    lamp_req = 1'b1;
    edges(wait_n);
    lit_in = 1'b1;
    edges(TWIN + 1 - wait_n);
    chk("R5", what, exp);
    settle();
  endtask

  task automatic t_release();
    lamp_req = 1'b1;
    edges(5);
    lamp_req = 1'b0;
    edges(1);
    chk("R8", "release during ignition", 3'b000);
    lamp_req = 1'b1;
    edges(TWIN);
    chk("R8", "fresh full window after restart", 3'b100);
    edges(1);
    chk("R8", "fault at end of fresh window", 3'b001);
    settle();
    lamp_req = 1'b1;
    lit_in   = 1'b1;
    edges(DEB + 4);
    chk("R8", "run reached before release", 3'b010);
    lamp_req = 1'b0;
    edges(1);
    chk("R8", "release during run", 3'b000);
    settle();
  endtask

  initial begin
    checks = 0; failures = 0; cyc = 0; done = 1'b0;
    t_reset();
    t_idle_lit();
    t_timeout();
    t_glitch_then_lit();
    t_loss_in_run();
    // qualification lands in the final window cycle: run wins (R5)
    t_lit_at_window_end(TWIN - 2 - DEB, 3'b010, "qualified in last window cycle");
    // one cycle later: window already expired
    t_lit_at_window_end(TWIN - 1 - DEB, 3'b001, "qualified one cycle too late");
    t_release();
    done = 1'b1;
    report();
    $finish;
  end
endmodule